// File: doc/BRIEF.md
# One-Time-Programmable Fuse Programming Controller

This block sits between a simple register bus and a one-time-programmable fuse array of 32-bit words. Software programs a word in three steps. It places a target word index and a one-shot unlock key in the control register, sets the strobe timing, and then writes the new value to the data register. The controller first senses the word's present contents and drops every bit that is already blown. It then moves the remaining bits out one at a time, least significant first, with a program strobe and a relax gap after each bit. While this runs, BUSY reads as 1.

A shadow array gives the bus a readable copy of the fuses, and software may also write it. Setting the reload bit copies every fuse word into the shadow array, one word per read-strobe interval. Per-word write-lock and read-lock inputs guard both the fuses and the shadows. Any violation raises a sticky ERROR flag, and while that flag stands the controller refuses new program, read and reload requests until software clears it. The fuse array is a behavioural model that only ever turns bits on.

Top module: `otpFuseCtrl`

## Requirements
- R1: Register offsets are: control at 0x000, its set alias at 0x004, its clear alias at 0x008, timing at 0x010, data at 0x020, and shadow word i at 0x400+4*i. The control register reads as {key[31:16], 5'b0, RELOAD[10], ERROR[9], BUSY[8], addr[7:0]} and is 0 after reset. Through an alias, a 1 sets or clears only that bit of addr or key, and BUSY cannot be written.
- R2: The timing register holds the program strobe length in bits 11:0, the relax count in bits 15:12 and the read strobe length in bits 21:16. All other bits read as 0.
- R3: A data write starts programming only when the key field equals 0x3E77. Without the key, the data register takes the value and BUSY stays 0.
- R4: An accepted data write sets BUSY and clears the key field to 0.
- R5: The bits programmed are the new data with every already-blown fuse bit removed. Exactly one strobe pulse occurs for each such bit, and the fuse word becomes old OR new.
- R6: The target index is latched on acceptance. Address writes during an operation do not change which word is programmed.
- R7: During programming, the data register shifts right with zero fill and reads 0 at the end. Bus writes to it while BUSY is set are ignored.
- R8: A keyed data write to a write-locked word, or to an index at or above the word count, sets ERROR. It leaves BUSY at 0 and the fuses unchanged.
- R9: A read of a read-locked shadow word returns 0xBADABADA and sets ERROR.
- R10: A shadow write during a reload, or to a write-locked word, sets ERROR and leaves the shadow unchanged. Any other shadow write stores the value.
- R11: ERROR is sticky. While it is set, program and reload requests are refused and shadow reads return 0xBADABADA. Only writing a 1 to bit 9 through the clear alias clears it.
- R12: Writing 1 to bit 10 copies every fuse word into the shadow array. RELOAD and BUSY stay set for NUM_WORDS*max(read,1) cycles and then clear themselves.
- R13: A program operation keeps BUSY set for max(read,1) + 32*(max(prog,1)+relax+1) cycles. The strobe is high for max(prog,1) cycles for each programmed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | BUS_AW | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational on busAddr |
| wrLock | input | NUM_WORDS | Per-word write lock |
| rdLock | input | NUM_WORDS | Per-word read lock |
| progStrobe | output | 1 | Fuse program strobe for the current bit |

## Verification
The hardest case to reach is a bus write that lands in the middle of a running operation: a new address and a full-ones data word sent while a program is shifting, or a shadow write sent while a reload is sweeping the array. The bench starts a program or reload with long strobe counts, issues those writes a fixed number of cycles later, and afterwards reloads and reads the shadows to confirm that only the latched word changed. Masking is shown by reprogramming the same words across a sweep of timing settings. Strobe pulses are counted against the popcount of new-and-not-old, and BUSY length is compared with the formula for each setting.

// File: rtl/otpPkg.sv
package otpPkg;
  localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [31:0] LOCKED_READ = 32'hBADABADA;

  // datapath -> control: decoded bus events and live timing fields
  typedef struct packed {
    logic        dataWr;
    logic        keyOk;
    logic        tgtWrLocked;
    logic        shWr;
    logic        shWrLocked;
    logic        shRd;
    logic        shRdLocked;
    logic        setReload;
    logic        clrErr;
    logic [11:0] progLen;
    logic [3:0]  relaxLen;
    logic [5:0]  readLen;
  } dpStatusT;

  // control -> datapath: strobes and state
  typedef struct packed {
    logic       accept;
    logic       shift;
    logic       blow;
    logic       strobeOn;
    logic       reloadWr;
    logic [7:0] reloadIdx;
    logic [4:0] bitIdx;
    logic       busy;
    logic       reloading;
    logic       error;
  } ctlCmdT;
endpackage

// File: rtl/otpFuseModel.sv
module otpFuseModel #(
  parameter int NUM_WORDS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  rdAddrA,
  output logic [31:0] rdDataA,
  input  logic [7:0]  rdAddrB,
  output logic [31:0] rdDataB,
  input  logic        blowEn,
  input  logic [7:0]  blowAddr,
  input  logic [4:0]  blowBit
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [31:0] fuse [NUM_WORDS];

  assign rdDataA = (int'(rdAddrA) < NUM_WORDS) ? fuse[rdAddrA[IDX_W-1:0]] : '0;
  assign rdDataB = (int'(rdAddrB) < NUM_WORDS) ? fuse[rdAddrB[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) fuse[i] <= '0;
    end else if (blowEn && int'(blowAddr) < NUM_WORDS) begin
      fuse[blowAddr[IDX_W-1:0]][blowBit] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_mono
    // R5
    fuse_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> ((fuse[g] & $past(fuse[g])) == $past(fuse[g])));
  end
endmodule

// File: rtl/otpDatapath.sv
module otpDatapath
  import otpPkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int BUS_AW    = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWe,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_WORDS-1:0] wrLock,
  input  logic [NUM_WORDS-1:0] rdLock,
  input  ctlCmdT               cmd,
  output dpStatusT             status,
  output logic                 progStrobe
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [BUS_AW-1:0] OFS_CTRL = BUS_AW'(12'h000);
  localparam logic [BUS_AW-1:0] OFS_SET  = BUS_AW'(12'h004);
  localparam logic [BUS_AW-1:0] OFS_CLR  = BUS_AW'(12'h008);
  localparam logic [BUS_AW-1:0] OFS_TIM  = BUS_AW'(12'h010);
  localparam logic [BUS_AW-1:0] OFS_DATA = BUS_AW'(12'h020);

  logic [7:0]  addrField;
  logic [15:0] keyField;
  logic [11:0] tProg;
  logic [3:0]  tRelax;
  logic [5:0]  tRead;
  logic [31:0] dataReg;
  logic [7:0]  latAddr;
  logic [31:0] shadow [NUM_WORDS];
  logic [31:0] senseWord, reloadWord;

  logic wrEn, rdEn, isCtrl, isSet, isClr, isTim, isData, isShadow, shInRange;
  logic [7:0] shIdx;

  assign wrEn      = busSel & busWe;
  assign rdEn      = busSel & ~busWe;
  assign isCtrl    = busAddr == OFS_CTRL;
  assign isSet     = busAddr == OFS_SET;
  assign isClr     = busAddr == OFS_CLR;
  assign isTim     = busAddr == OFS_TIM;
  assign isData    = busAddr == OFS_DATA;
  assign isShadow  = (busAddr[BUS_AW-1:10] == (BUS_AW-10)'(1)) && (busAddr[1:0] == 2'b00);
  assign shIdx     = busAddr[9:2];
  assign shInRange = int'(shIdx) < NUM_WORDS;

  always_comb begin
    status             = '0;
    status.dataWr      = wrEn & isData;
    status.keyOk       = keyField == UNLOCK_KEY;
    status.tgtWrLocked = (int'(addrField) >= NUM_WORDS) || wrLock[addrField[IDX_W-1:0]];
    status.shWr        = wrEn & isShadow & shInRange;
    status.shWrLocked  = shInRange && wrLock[shIdx[IDX_W-1:0]];
    status.shRd        = rdEn & isShadow & shInRange;
    status.shRdLocked  = shInRange && rdLock[shIdx[IDX_W-1:0]];
    status.setReload   = wrEn & (isCtrl | isSet) & busWdata[10];
    status.clrErr      = wrEn & isClr & busWdata[9];
    status.progLen     = tProg;
    status.relaxLen    = tRelax;
    status.readLen     = tRead;
  end

  otpFuseModel #(.NUM_WORDS(NUM_WORDS)) fuse_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (addrField),
    .rdDataA (senseWord),
    .rdAddrB (cmd.reloadIdx),
    .rdDataB (reloadWord),
    .blowEn  (cmd.blow & dataReg[0]),
    .blowAddr(latAddr),
    .blowBit (cmd.bitIdx)
  );

  assign progStrobe = cmd.strobeOn & dataReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrField <= '0;
      keyField  <= '0;
      tProg     <= '0;
      tRelax    <= '0;
      tRead     <= '0;
      dataReg   <= '0;
      latAddr   <= '0;
      for (int i = 0; i < NUM_WORDS; i++) shadow[i] <= '0;
    end else begin
      if (wrEn && isCtrl) begin
        addrField <= busWdata[7:0];
        keyField  <= busWdata[31:16];
      end else if (wrEn && isSet) begin
        addrField <= addrField | busWdata[7:0];
        keyField  <= keyField | busWdata[31:16];
      end else if (wrEn && isClr) begin
        addrField <= addrField & ~busWdata[7:0];
        keyField  <= keyField & ~busWdata[31:16];
      end
      if (cmd.accept) begin
        keyField <= '0;
        latAddr  <= addrField;
      end
      if (wrEn && isTim) begin
        tProg  <= busWdata[11:0];
        tRelax <= busWdata[15:12];
        tRead  <= busWdata[21:16];
      end
      if (cmd.accept) dataReg <= busWdata & ~senseWord;
      else if (wrEn && isData && !cmd.busy) dataReg <= busWdata;
      else if (cmd.shift) dataReg <= {1'b0, dataReg[31:1]};
      if (cmd.reloadWr) shadow[cmd.reloadIdx[IDX_W-1:0]] <= reloadWord;
      else if (status.shWr && !status.shWrLocked && !cmd.reloading)
        shadow[shIdx[IDX_W-1:0]] <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (isCtrl || isSet || isClr)
      busRdata = {keyField, 5'b0, cmd.reloading, cmd.error, cmd.busy, addrField};
    else if (isTim) busRdata = {10'b0, tRead, tRelax, tProg};
    else if (isData) busRdata = dataReg;
    else if (isShadow && shInRange)
      busRdata = (status.shRdLocked || cmd.error) ? LOCKED_READ : shadow[shIdx[IDX_W-1:0]];
  end

  // R4
  key_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.accept |=> keyField == 16'h0);
  // R6
  target_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.busy |=> $stable(latAddr));
  // R7
  data_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.busy && !cmd.shift) |=> $stable(dataReg));
  // R9
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status.shRd && status.shRdLocked) |-> busRdata == LOCKED_READ);
endmodule

// File: rtl/otpControl.sv
module otpControl
  import otpPkg::*;
#(
  parameter int NUM_WORDS = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpStatusT status,
  output ctlCmdT   cmd
);
  typedef enum logic [2:0] {IDLE, SENSE, STROBE, RELAX, RELOAD} stateT;

  stateT       state;
  logic [11:0] cnt;
  logic [4:0]  bitIdx;
  logic [7:0]  rIdx;
  logic        err;
  logic        busy, accept, lockHit, reloadGo, errSet;
  logic [11:0] senseLen, strobeLen;

  assign busy      = state != IDLE;
  assign accept    = status.dataWr & ~busy & ~err & status.keyOk & ~status.tgtWrLocked;
  assign lockHit   = status.dataWr & ~busy & ~err & status.keyOk & status.tgtWrLocked;
  assign reloadGo  = status.setReload & ~busy & ~err;
  assign errSet    = lockHit | (status.shRd & status.shRdLocked)
                   | (status.shWr & (status.shWrLocked | (state == RELOAD)));
  assign senseLen  = (status.readLen == 6'd0) ? 12'd1 : {6'b0, status.readLen};
  assign strobeLen = (status.progLen == 12'd0) ? 12'd1 : status.progLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      rIdx   <= '0;
      err    <= 1'b0;
    end else begin
      if (errSet) err <= 1'b1;
      else if (status.clrErr) err <= 1'b0;
      case (state)
        IDLE: begin
          if (accept) begin
            state <= SENSE;
            cnt   <= senseLen - 12'd1;
          end else if (reloadGo) begin
            state <= RELOAD;
            cnt   <= senseLen - 12'd1;
            rIdx  <= '0;
          end
        end
        SENSE: begin
          if (cnt == 12'd0) begin
            state  <= STROBE;
            cnt    <= strobeLen - 12'd1;
            bitIdx <= '0;
          end else cnt <= cnt - 12'd1;
        end
        STROBE: begin
          if (cnt == 12'd0) begin
            state <= RELAX;
            cnt   <= {8'b0, status.relaxLen};
          end else cnt <= cnt - 12'd1;
        end
        RELAX: begin
          if (cnt == 12'd0) begin
            if (bitIdx == 5'd31) state <= IDLE;
            else begin
              state  <= STROBE;
              cnt    <= strobeLen - 12'd1;
              bitIdx <= bitIdx + 5'd1;
            end
          end else cnt <= cnt - 12'd1;
        end
        RELOAD: begin
          if (cnt == 12'd0) begin
            if (int'(rIdx) == NUM_WORDS - 1) state <= IDLE;
            else begin
              rIdx <= rIdx + 8'd1;
              cnt  <= senseLen - 12'd1;
            end
          end else cnt <= cnt - 12'd1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.accept    = accept;
    cmd.shift     = (state == RELAX) && (cnt == 12'd0);
    cmd.blow      = (state == STROBE) && (cnt == 12'd0);
    cmd.strobeOn  = state == STROBE;
    cmd.reloadWr  = (state == RELOAD) && (cnt == 12'd0);
    cmd.reloadIdx = rIdx;
    cmd.bitIdx    = bitIdx;
    cmd.busy      = busy;
    cmd.reloading = state == RELOAD;
    cmd.error     = err;
  end

  // R11
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (err && !status.clrErr) |=> err);
  // R8
  locked_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status.dataWr && status.tgtWrLocked && !busy) |=> !busy);
endmodule

// File: rtl/otpFuseCtrl.sv
module otpFuseCtrl
  import otpPkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int BUS_AW    = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWe,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_WORDS-1:0] wrLock,
  input  logic [NUM_WORDS-1:0] rdLock,
  output logic                 progStrobe
);
  dpStatusT status;
  ctlCmdT   cmd;

  otpDatapath #(.NUM_WORDS(NUM_WORDS), .BUS_AW(BUS_AW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .wrLock    (wrLock),
    .rdLock    (rdLock),
    .cmd       (cmd),
    .status    (status),
    .progStrobe(progStrobe)
  );

  otpControl #(.NUM_WORDS(NUM_WORDS)) ctl_i (
    .clk   (clk),
    .rstN  (rstN),
    .status(status),
    .cmd   (cmd)
  );
endmodule

// File: tb/otpFuseCtrl_tb_top.sv
`timescale 1ns/1ps
module otpFuseCtrl_tb_top;
  localparam int NW = 16;
  localparam logic [11:0] A_CTRL = 12'h000, A_SET = 12'h004, A_CLR = 12'h008;
  localparam logic [11:0] A_TIM = 12'h010, A_DATA = 12'h020, A_SH = 12'h400;
  localparam logic [31:0] BAD = 32'hBADABADA;

  logic clk = 1'b0, rstN = 1'b0, busSel = 1'b0, busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NW-1:0] wrLock = '0, rdLock = '0;
  logic progStrobe;
  int vectors = 0, miscompares = 0;
  logic [31:0] model [NW];
  logic [31:0] d;

  always #2 clk = ~clk;

  otpFuseCtrl #(.NUM_WORDS(NW), .BUS_AW(12)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wrLock(wrLock), .rdLock(rdLock),
    .progStrobe(progStrobe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    @(negedge clk); busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = v;
    @(negedge clk); busSel = 1'b0; busWe = 1'b0; busAddr = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 v = busRdata;
    @(negedge clk); busSel = 1'b0; busAddr = '0;
  endtask

  // watches control register (address 0) until BUSY drops
  task automatic watch(output int busyCyc, output int hiCyc, output int pulses, output logic sawReload);
    logic prev;
    prev = 1'b0; busyCyc = 0; hiCyc = 0; pulses = 0;
    #1 sawReload = busRdata[10];
    while (busRdata[8] === 1'b1) begin
      busyCyc++;
      if (progStrobe) begin
        hiCyc++;
        if (!prev) pulses++;
      end
      prev = progStrobe;
      @(negedge clk); #1;
    end
  endtask

  task automatic prog(int w, logic [31:0] v, int p, int r, int s);
    int bc, hc, pc, pe, se;
    logic sr;
    logic [31:0] nb, c;
    wr(A_TIM, {10'b0, 6'(s), 4'(r), 12'(p)});
    wr(A_CTRL, {16'h3E77, 8'h00, 8'(w)});
    wr(A_DATA, v);
    watch(bc, hc, pc, sr);
    nb = v & ~model[w];
    model[w] = model[w] | v;
    pe = (p == 0) ? 1 : p;
    se = (s == 0) ? 1 : s;
    check("R13 busy length", 32'(bc), 32'(se + 32 * (pe + r + 1)));
    check("R5 strobe pulses", 32'(pc), 32'($countones(nb)));
    check("R13 strobe width", 32'(hc), 32'($countones(nb) * pe));
    rd(A_DATA, c);
    check("R7 data drained", c, 32'h0);
    rd(A_CTRL, c);
    check("R4 key consumed", {16'h0, c[31:16]}, 32'h0);
  endtask

  task automatic reload(int s);
    int bc, hc, pc;
    logic sr;
    logic [31:0] c;
    wr(A_TIM, {10'b0, 6'(s), 16'h0});
    wr(A_SET, 32'h0000_0400);
    watch(bc, hc, pc, sr);
    check("R12 reload flag", 32'(sr), 32'h1);
    check("R12 reload length", 32'(bc), 32'(NW * ((s == 0) ? 1 : s)));
    rd(A_CTRL, c);
    check("R12 flag self-clear", {31'b0, c[10]}, 32'h0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int bc, hc, pc;
    logic sr;
    logic [31:0] v;
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl reset", d, 32'h0);
    rd(A_TIM, d);  check("R2 timing reset", d, 32'h0);
    rd(A_DATA, d); check("R7 data reset", d, 32'h0);
    rd(A_SH + 12'h004, d); check("R1 shadow reset", d, 32'h0);

    // R1 aliases
    wr(A_CTRL, 32'h3E77_0005);
    wr(A_SET, 32'h0000_01A0);
    rd(A_CTRL, d); check("R1 set alias", d, 32'h3E77_00A5);
    wr(A_CLR, 32'h0000_0005);
    rd(A_CTRL, d); check("R1 clear alias", d, 32'h3E77_00A0);
    wr(A_CLR, 32'hFFFF_0000);
    rd(A_CTRL, d); check("R1 clear key", d, 32'h0000_00A0);

    // R2 timing fields
    wr(A_TIM, 32'hFFFF_FFFF);
    rd(A_TIM, d); check("R2 timing mask", d, 32'h003F_FFFF);

    // R3 no key
    wr(A_CTRL, 32'h0000_0001);
    wr(A_DATA, 32'h0000_0055);
    #1 check("R3 no busy without key", {31'b0, busRdata[8]}, 32'h0);
    rd(A_DATA, d); check("R3 data stored", d, 32'h0000_0055);

    // R5 / R13 sweep over timing, words reused to exercise masking
    for (int i = 0; i < 18; i++) begin
      v = (32'h9E37_79B9 * 32'(i + 1)) ^ (32'(i) << 5);
      prog(i % 12, v, i % 3, (i / 3) % 2, (i / 6) % 3);
    end
    reload(2);
    for (int i = 0; i < NW; i++) begin
      rd(A_SH + 12'(4 * i), d); check("R12 R5 shadow copy", d, model[i]);
    end

    // R6 / R7 writes during an operation
    wr(A_TIM, {10'b0, 6'd1, 4'd1, 12'd3});
    wr(A_CTRL, {16'h3E77, 16'd12});
    wr(A_DATA, 32'h0000_F00F);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h0000_000D);
    wr(A_DATA, 32'hFFFF_FFFF);
    watch(bc, hc, pc, sr);
    model[12] = model[12] | 32'h0000_F00F;
    rd(A_DATA, d); check("R7 mid-op data write ignored", d, 32'h0);
    reload(1);
    rd(A_SH + 12'h030, d); check("R6 latched target programmed", d, model[12]);
    rd(A_SH + 12'h034, d); check("R6 other word untouched", d, model[13]);

    // R8 write lock and out-of-range index
    wrLock = 16'h0020;
    wr(A_CTRL, {16'h3E77, 16'd5});
    wr(A_DATA, 32'hFFFF_FFFF);
    #1 check("R8 no busy on locked word", {31'b0, busRdata[8]}, 32'h0);
    rd(A_CTRL, d); check("R8 error on locked word", d, 32'h3E77_0205);
    wr(A_CLR, 32'h0000_0200);
    rd(A_CTRL, d); check("R11 clear alias clears error", d, 32'h3E77_0005);
    wr(A_CTRL, {16'h3E77, 16'd20});
    wr(A_DATA, 32'h0000_0001);
    rd(A_CTRL, d); check("R8 error on out-of-range index", d, 32'h3E77_0214);
    wr(A_CLR, 32'h0000_0200);
    wrLock = '0;

    // R9 read lock
    rdLock = 16'h0008;
    rd(A_SH + 12'h00C, d); check("R9 locked read value", d, BAD);
    rd(A_CTRL, d); check("R9 error set", {31'b0, d[9]}, 32'h1);

    // R11 refusals while ERROR
    wr(A_CTRL, {16'h3E77, 16'd6});
    wr(A_DATA, 32'h0000_0001);
    rd(A_CTRL, d); check("R11 program refused", d, 32'h3E77_0206);
    wr(A_SET, 32'h0000_0400);
    rd(A_CTRL, d); check("R11 reload refused", {29'b0, d[10:8]}, 32'h2);
    rd(A_SH + 12'h000, d); check("R11 read refused", d, BAD);
    wr(A_CTRL, 32'h0000_0006);
    rd(A_CTRL, d); check("R11 direct write keeps error", d, 32'h0000_0206);
    wr(A_CLR, 32'h0000_0200);
    rd(A_CTRL, d); check("R11 cleared", d, 32'h0000_0006);
    rdLock = '0;
    rd(A_SH + 12'h000, d); check("R11 read after clear", d, model[0]);

    // R10 shadow writes
    wrLock = 16'h0080;
    wr(A_SH + 12'h01C, 32'h0000_DEAD);
    rd(A_CTRL, d); check("R10 locked shadow write error", {31'b0, d[9]}, 32'h1);
    wr(A_CLR, 32'h0000_0200);
    rd(A_SH + 12'h01C, d); check("R10 locked shadow unchanged", d, model[7]);
    wr(A_SH + 12'h020, 32'h1234_5678);
    rd(A_SH + 12'h020, d); check("R10 shadow writable", d, 32'h1234_5678);
    wr(A_TIM, {10'b0, 6'd6, 16'h0});
    wr(A_SET, 32'h0000_0400);
    wr(A_SH + 12'h008, 32'hCAFE_F00D);
    watch(bc, hc, pc, sr);
    rd(A_CTRL, d); check("R10 write during reload error", {31'b0, d[9]}, 32'h1);
    wr(A_CLR, 32'h0000_0200);
    rd(A_SH + 12'h008, d); check("R10 reload write discarded", d, model[2]);
    rd(A_SH + 12'h020, d); check("R12 reload overwrites shadow", d, model[8]);
    rd(A_SH + 12'h014, d); check("R8 locked fuse unchanged", d, model[5]);
    wrLock = '0;

    finishRun();
  end
endmodule